// File: doc/BRIEF.md
# Pre/Post Trigger Capture Controller

This block sits between a set of probed signals and a circular capture memory. Once armed, it produces one write slot per clock and walks the write address through a ring whose length is the configured depth. Alongside, it watches a single trigger line for a selectable condition. A trigger is accepted only after the part of the ring reserved for pre-trigger history has been filled. Once a trigger is accepted, the block keeps recording until the post-trigger share of the window is complete. It then stops, pulses `finish` for one cycle and holds the ring address where the captured window begins. The sample stream reaches the block `LAT` cycles after the trigger line it belongs to, so the write strobe and address are delayed by `LAT` cycles to line up with `samp_in`.

The controller is a five-state machine. ST_IDLE holds until `arm`. ST_FILL records the pre-trigger share and moves to ST_WAIT after its last slot. ST_WAIT keeps recording and ring-wrapping until the trigger condition holds. From there it goes to ST_POST, or straight to ST_DONE when the post share is a single slot. ST_POST records the rest of the post share and moves to ST_DONE. ST_DONE lasts one cycle and returns to ST_IDLE. `arm` from any state moves to ST_FILL. Configuration is latched at `arm`.

Top module: `cap_ctrl`

## Requirements
- R1: While `rst_n` is low, `wr_en`, `finish` and `win_start` are all 0.
- R2: The cycle after `arm` is sampled high, recording starts with slot address 0. Each following recording cycle advances the address by one and wraps from depth-1 to 0. Depth is `depth_cfg` clamped into the range 4 to 2^AW. An `arm` during a capture restarts it.
- R3: A slot recorded in cycle k appears on the ports in cycle k+LAT as `wr_en`=1 with its address. In the same cycle, `wr_data` carries `samp_in`.
- R4: Trigger condition `trig_mode` is 0 = rising edge, 1 = falling edge, 2 = high level and 3 = low level. Edges compare `trig_in` with its value one cycle earlier.
- R5: Any trigger condition present while the pre-trigger share is still being filled is ignored.
- R6: `split_sel` gives the post-trigger percentage: 0 = 70, 1 = 50, 2 = 30 and 3 = 50. The post count is floor(depth*pct/100), and the pre count is depth minus the post count.
- R7: The trigger slot counts as the first post-trigger slot. Exactly post-count slots are recorded from it onward, and then recording stops.
- R8: `finish` is high for exactly one cycle, in the cycle after the last post-trigger slot.
- R9: From the cycle after the trigger slot, `win_start` equals (trigger slot address − pre count) mod depth. It holds that value until the next accepted trigger.
- R10: After a capture ends, no slot is recorded and no trigger is accepted until the next `arm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm | input | 1 | Latch configuration and start recording |
| trig_mode | input | 2 | Trigger condition select |
| split_sel | input | 2 | Pre/post split select |
| depth_cfg | input | AW+1 | Requested window depth |
| trig_in | input | 1 | Trigger line, sampled every clock |
| samp_in | input | DW | Sample vector, arriving LAT cycles late |
| wr_en | output | 1 | Capture memory write strobe |
| wr_addr | output | AW | Capture memory write address |
| wr_data | output | DW | Capture memory write data |
| finish | output | 1 | One-cycle capture-complete pulse |
| win_start | output | AW | Ring address of the oldest sample in the window |

## Verification
Each trigger condition is tried with a waveform that also contains the other conditions. A rising edge placed inside the fill phase tells an ignored early trigger apart from an accepted one. A long high run before a falling edge separates edge detection from level detection. Depths that are clamped at both ends, together with all three split settings, distinguish the floor rounding, the single-slot post path and ring wrap-around. A low-level trigger left active after the capture and a re-arm in the middle of a capture show whether the one-shot stop and the restart work.

// File: rtl/cap_pkg.sv
package cap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_WAIT,
        ST_POST,
        ST_DONE
    } cap_state_t;

    typedef enum logic [1:0] {
        TRG_RISE = 2'd0,
        TRG_FALL = 2'd1,
        TRG_HIGH = 2'd2,
        TRG_LOW  = 2'd3
    } trg_mode_t;

    // Percentage of the window that follows the trigger
    function automatic logic [6:0] post_pct(input logic [1:0] sel);
        unique case (sel)
            2'd0:    return 7'd70;
            2'd2:    return 7'd30;
            default: return 7'd50;
        endcase
    endfunction

endpackage

// File: rtl/cap_trig_detect.sv
module cap_trig_detect
    import cap_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      trig_in,
    input  trg_mode_t mode,
    output logic      hit
);
    logic trig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_in;
    end

    always_comb begin
        unique case (mode)
            TRG_RISE: hit = trig_in & ~trig_q;
            TRG_FALL: hit = ~trig_in & trig_q;
            TRG_HIGH: hit = trig_in;
            TRG_LOW:  hit = ~trig_in;
            default:  hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/cap_wr_align.sv
module cap_wr_align #(
    parameter int AW  = 5,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [AW-1:0] in_addr,
    output logic          out_vld,
    output logic [AW-1:0] out_addr
);
    generate
        if (LAT == 0) begin : g_none
            assign out_vld  = in_vld;
            assign out_addr = in_addr;
        end else begin : g_pipe
            logic [LAT-1:0] vld_q;
            logic [AW-1:0]  addr_q [LAT];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q <= '0;
                    for (int i = 0; i < LAT; i++) addr_q[i] <= '0;
                end else begin
                    vld_q[0]  <= in_vld;
                    addr_q[0] <= in_addr;
                    for (int i = 1; i < LAT; i++) begin
                        vld_q[i]  <= vld_q[i-1];
                        addr_q[i] <= addr_q[i-1];
                    end
                end
            end

            assign out_vld  = vld_q[LAT-1];
            assign out_addr = addr_q[LAT-1];
        end
    endgenerate
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
    import cap_pkg::*;
#(
    parameter int DW  = 8,
    parameter int AW  = 5,
    parameter int LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm,
    input  logic [1:0]    trig_mode,
    input  logic [1:0]    split_sel,
    input  logic [AW:0]   depth_cfg,
    input  logic          trig_in,
    input  logic [DW-1:0] samp_in,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          finish,
    output logic [AW-1:0] win_start
);
    localparam int DCW = AW + 1;
    localparam logic [DCW-1:0] MIN_DEPTH = DCW'(4);
    localparam logic [DCW-1:0] MAX_DEPTH = DCW'(1 << AW);

    cap_state_t     state, state_nx;
    trg_mode_t      mode_r;
    logic [DCW-1:0] depth_r, pre_r, post_r, cnt_r;
    logic [AW-1:0]  addr_r, win_r;
    logic           hit, slot_we;

    // Configuration derived at arm time
    logic [DCW-1:0] depth_c, post_c, pre_c;
    logic [31:0]    prod_c;

    always_comb begin
        if (depth_cfg < MIN_DEPTH)      depth_c = MIN_DEPTH;
        else if (depth_cfg > MAX_DEPTH) depth_c = MAX_DEPTH;
        else                            depth_c = depth_cfg;
        prod_c = 32'(depth_c) * 32'(post_pct(split_sel));
        post_c = DCW'(prod_c / 32'd100);
        pre_c  = depth_c - post_c;
    end

    cap_trig_detect u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig_in (trig_in),
        .mode    (mode_r),
        .hit     (hit)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        if (arm) begin
            state_nx = ST_FILL;
        end else begin
            unique case (state)
                ST_IDLE: state_nx = ST_IDLE;
                ST_FILL: if (cnt_r + 1'b1 == pre_r) state_nx = ST_WAIT;
                ST_WAIT: if (hit) state_nx = (post_r == DCW'(1)) ? ST_DONE : ST_POST;
                ST_POST: if (cnt_r + 1'b1 == post_r) state_nx = ST_DONE;
                ST_DONE: state_nx = ST_IDLE;
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Moore outputs
    always_comb begin
        slot_we = 1'b0;
        finish  = 1'b0;
        unique case (state)
            ST_FILL, ST_WAIT, ST_POST: slot_we = 1'b1;
            ST_DONE:                   finish  = 1'b1;
            default: ;
        endcase
    end

    // Window start for a trigger at the current slot
    logic [DCW-1:0] addr_ext, ws_c;
    always_comb begin
        addr_ext = {1'b0, addr_r};
        ws_c = (addr_ext >= pre_r) ? (addr_ext - pre_r) : (addr_ext + depth_r - pre_r);
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_r  <= TRG_RISE;
            depth_r <= MIN_DEPTH;
            pre_r   <= MIN_DEPTH;
            post_r  <= '0;
            cnt_r   <= '0;
            addr_r  <= '0;
            win_r   <= '0;
        end else if (arm) begin
            mode_r  <= trg_mode_t'(trig_mode);
            depth_r <= depth_c;
            pre_r   <= pre_c;
            post_r  <= post_c;
            cnt_r   <= '0;
            addr_r  <= '0;
        end else begin
            if (slot_we)
                addr_r <= (addr_ext == depth_r - 1'b1) ? '0 : addr_r + 1'b1;
            unique case (state)
                ST_FILL: cnt_r <= cnt_r + 1'b1;
                ST_WAIT: if (hit) begin
                    cnt_r <= DCW'(1);
                    win_r <= ws_c[AW-1:0];
                end
                ST_POST: cnt_r <= cnt_r + 1'b1;
                default: ;
            endcase
        end
    end

    cap_wr_align #(.AW(AW), .LAT(LAT)) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_vld   (slot_we),
        .in_addr  (addr_r),
        .out_vld  (wr_en),
        .out_addr (wr_addr)
    );

    assign wr_data   = samp_in;
    assign win_start = win_r;

    // R8
    finish_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> !finish);

    // R2
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_we |-> ({1'b0, addr_r} < depth_r));

    // R2
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_we && $past(slot_we) && !$past(arm)) |->
        ({1'b0, addr_r} == (({1'b0, $past(addr_r)} == $past(depth_r) - 1'b1)
                            ? DCW'(0) : {1'b0, $past(addr_r)} + 1'b1)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !arm) |=> (state == ST_IDLE && !slot_we));

    // R5
    fill_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FILL && !arm) |=> (state != ST_POST && state != ST_DONE));

    // R7
    trig_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && hit && !arm) |=> (state == ST_POST || state == ST_DONE));
endmodule

// File: tb/tb_cap_ctrl.sv
`timescale 1ns/1ps
module tb_cap_ctrl;
    localparam int DW  = 8;
    localparam int AW  = 5;
    localparam int LAT = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          arm = 1'b0;
    logic [1:0]    trig_mode = '0;
    logic [1:0]    split_sel = '0;
    logic [AW:0]   depth_cfg = '0;
    logic          trig_in = 1'b0;
    logic [DW-1:0] samp_in = '0;
    logic          wr_en, finish;
    logic [AW-1:0] wr_addr, win_start;
    logic [DW-1:0] wr_data;

    always #4 clk = ~clk;

    cap_ctrl #(.DW(DW), .AW(AW), .LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .trig_mode(trig_mode),
        .split_sel(split_sel), .depth_cfg(depth_cfg), .trig_in(trig_in),
        .samp_in(samp_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .finish(finish), .win_start(win_start)
    );

    int checks = 0, fails = 0, run_wr = 0, run_fin = 0;
    bit done = 0;

    // Behavioural reference model: 0 idle, 1 fill, 2 wait, 3 post, 4 done
    int m_st = 0, m_cnt = 0, m_addr = 0, m_depth = 4, m_pre = 4, m_post = 0;
    int m_mode = 0, m_win = 0, m_prev = 0;
    int q_we[$], q_ad[$];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int adv(input int a);
        return (a == m_depth - 1) ? 0 : a + 1;
    endfunction

    task automatic model_step(input int a, input int t);
        int hit, pct;
        unique case (m_mode)
            0: hit = (t == 1 && m_prev == 0) ? 1 : 0;
            1: hit = (t == 0 && m_prev == 1) ? 1 : 0;
            2: hit = t;
            default: hit = (t == 0) ? 1 : 0;
        endcase
        if (a != 0) begin
            m_depth = int'(depth_cfg);
            if (m_depth < 4) m_depth = 4;
            if (m_depth > 32) m_depth = 32;
            pct = (split_sel == 0) ? 70 : (split_sel == 2) ? 30 : 50;
            m_post = m_depth * pct / 100;
            m_pre = m_depth - m_post;
            m_mode = int'(trig_mode);
            m_st = 1; m_cnt = 0; m_addr = 0;
        end else begin
            case (m_st)
                1: begin
                    m_addr = adv(m_addr);
                    m_cnt++;
                    if (m_cnt == m_pre) m_st = 2;
                end
                2: begin
                    if (hit != 0) begin
                        m_win = (m_addr - m_pre + m_depth) % m_depth;
                        m_st = (m_post == 1) ? 4 : 3;
                        m_cnt = 1;
                    end
                    m_addr = adv(m_addr);
                end
                3: begin
                    m_addr = adv(m_addr);
                    if (m_cnt + 1 == m_post) m_st = 4;
                    else m_cnt++;
                end
                4: m_st = 0;
                default: ;
            endcase
        end
        m_prev = t;
        q_we.push_back((m_st >= 1 && m_st <= 3) ? 1 : 0);
        q_ad.push_back(m_addr);
        void'(q_we.pop_front());
        void'(q_ad.pop_front());
    endtask

    task automatic compare();
        chk("R3 wr_en", int'(wr_en), q_we[0]);
        if (q_we[0] != 0) begin
            chk("R2 wr_addr", int'(wr_addr), q_ad[0]);
            chk("R3 wr_data", int'(wr_data), int'(samp_in));
        end
        chk("R8 finish", int'(finish), (m_st == 4) ? 1 : 0);
        chk("R9 win_start", int'(win_start), m_win);
        if (wr_en) run_wr++;
        if (finish) run_fin++;
    endtask

    task automatic step(input logic a, input logic t);
        arm = a;
        trig_in = t;
        samp_in = DW'($urandom);
        @(posedge clk);
        model_step(int'(a), int'(t));
        @(negedge clk);
        compare();
    endtask

    task automatic run(input int md, input int sp, input int dc, input logic [63:0] pat,
                       input int n, input int rearm, input int exp_wr, input int exp_ws,
                       input string tag);
        trig_mode = 2'(md);
        split_sel = 2'(sp);
        depth_cfg = (AW+1)'(dc);
        run_wr = 0;
        run_fin = 0;
        step(1'b1, 1'b0);
        for (int i = 0; i < n; i++) step(i == rearm, pat[i]);
        arm = 1'b0;
        chk({tag, " write count"}, run_wr, exp_wr);
        chk({tag, " R8 finish count"}, run_fin, 1);
        chk({tag, " R9 window start"}, int'(win_start), exp_ws);
    endtask

    initial begin
        for (int i = 0; i <= LAT; i++) begin
            q_we.push_back(0);
            q_ad.push_back(0);
        end
        repeat (3) @(negedge clk);
        chk("R1 wr_en in reset", int'(wr_en), 0);
        chk("R1 finish in reset", int'(finish), 0);
        chk("R1 win_start in reset", int'(win_start), 0);
        rst_n = 1'b1;
        repeat (2) step(1'b0, 1'b0);

        // Rising edge: early rise during fill ignored, later rise accepted
        run(0, 1, 16, ({64{1'b1}} << 12) | 64'h38, 40, -1, 20, 4, "R4 R5 rise");
        // Falling edge, 30/70 split, ring wrap at depth 10
        run(1, 0, 10, 64'h3F, 30, -1, 13, 3, "R4 R6 fall");
        // High level, depth clamped up to 4, single-slot post share
        run(2, 2, 0, {64{1'b1}}, 12, -1, 4, 0, "R4 R6 high");
        // Low level, depth clamped down to 32, trigger stays active afterwards
        run(3, 3, 63, 64'hFFFFF, 60, -1, 36, 4, "R4 R10 low");
        // Re-arm in the middle of a capture
        run(2, 1, 8, {64{1'b1}} << 6, 30, 5, 14, 0, "R2 rearm");

        repeat (5) step(1'b0, 1'b1);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule